// File: doc/BRIEF.md
# Serial ADC Output Emulator

This block stands in for the serial output side of a 10- or 12-bit sampling converter, so a host controller can be tested against it. A system clock samples the host's chip select and serial clock lines. A parallel sample word arrives on its own input. When chip select falls, the block takes a copy of the sample and enters hold. It then drives a 16-bit word, made up of leading zeros and the data, one bit per serial clock falling edge. It gives the data line back either when the word is finished or as soon as chip select rises.

The data line is brought out as a value and an output enable, and the pad is built outside the block. A track/hold status output follows the converter's acquisition timing. A one-cycle pulse reports how each frame ended: either it completed or it was cut short. The host's lines must be synchronous to the system clock, and each of their levels must last at least one system clock.

Top module: `adcemu_port`

## Requirements
- R1: One system clock after chip select is seen falling, `sdo_oe` and `hold` are 1 and `sdo` shows the first leading zero. The sample is latched at that edge, and later changes of `sample` have no effect on the frame.
- R2: `sdo` changes only one system clock after a serial clock falling edge is seen during an active frame. A rising edge leaves it unchanged.
- R3: With `mode10` = 0, the 16 bits driven, in order, are four zeros and then `sample[11:0]` MSB first.
- R4: With `mode10` = 1, the 16 bits are four zeros, then `sample[9:0]` MSB first, then two zeros.
- R5: `hold` stays 1 through the 13th serial clock falling edge. It goes to 0 one system clock after the next serial clock rising edge.
- R6: The 16th falling edge of a frame sets `sdo_oe` to 0 and `done` pulses in the same cycle.
- R7: If chip select rises before the required count of falling edges (16 for 12-bit, 14 for 10-bit), then one system clock later `sdo_oe` and `hold` are 0 and `abort` pulses.
- R8: In 10-bit mode, a chip select rise after 14 or 15 falling edges ends the frame with `done`, not `abort`.
- R9: Serial clock edges while chip select is high, or after a frame has ended, change no output. Every chip select fall restarts the frame from the first leading zero.
- R10: `done` and `abort` last one cycle each and are never 1 together. Each frame produces exactly one of them.
- R11: In reset and after it, `sdo_oe`, `sdo`, `hold`, `done` and `abort` are 0. `sdo` is 0 whenever `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the host lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| sclk | input | 1 | Host serial clock |
| sample | input | 12 | Parallel sample value |
| mode10 | input | 1 | 1 selects the 10-bit frame |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial data enable, 0 means high impedance |
| hold | output | 1 | 1 while in hold, 0 while tracking |
| done | output | 1 | Pulse: frame completed |
| abort | output | 1 | Pulse: frame cut short |

## Verification
Each result is due exactly one system clock after the input edge that causes it is sampled: `sdo`, `sdo_oe` and `hold` after a chip select or serial clock edge, and `done` or `abort` after the ending edge. The bench changes inputs on the falling system clock edge. A reference model updates on the rising edge from the same inputs and is compared with the outputs on the next falling edge, half a period after they settle. Directed frames rebuild the serial word from `sdo`, sampled two system clocks after each serial clock fall, and count the end pulses.

// File: rtl/adcemu_pkg.sv
package adcemu_pkg;
  localparam int unsigned FRAME_W    = 16;
  localparam int unsigned DATA_W     = 12;
  localparam int unsigned SHORT_W    = 10;
  localparam int unsigned LEAD_ZEROS = 4;
  localparam int unsigned TRACK_AT   = 13;
  localparam int unsigned SHORT_NEED = LEAD_ZEROS + SHORT_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_W + 1);

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [CNT_W-1:0]   fcnt_t;
endpackage

// File: rtl/adcemu_edge.sv
module adcemu_edge #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= lvl;
  end

  assign rise = !prev_q && lvl;
  assign fall = prev_q && !lvl;
endmodule

// File: rtl/adcemu_frame.sv
module adcemu_frame
  import adcemu_pkg::*;
#(
  parameter int unsigned FW   = FRAME_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned SW   = SHORT_W,
  parameter int unsigned LZ   = LEAD_ZEROS
) (
  input  logic [DW-1:0] sample,
  input  logic          short_mode,
  output logic [FW-1:0] word
);
  localparam int unsigned TAIL = FW - LZ - SW;
  logic [FW-1:0] long_w;
  logic [FW-1:0] short_w;

  always_comb begin
    long_w  = '0;
    short_w = '0;
    for (int b = 0; b < int'(DW); b++) long_w[b] = sample[b];
    for (int b = 0; b < int'(SW); b++) short_w[b + int'(TAIL)] = sample[b];
  end

  assign word = short_mode ? short_w : long_w;
endmodule

// File: rtl/adcemu_port.sv
module adcemu_port
  import adcemu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample,
  input  logic              mode10,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              hold,
  output logic              done,
  output logic              abort
);
  localparam fcnt_t LAST_CNT  = fcnt_t'(FRAME_W);
  localparam fcnt_t LONG_REQ  = fcnt_t'(FRAME_W);
  localparam fcnt_t SHORT_REQ = fcnt_t'(SHORT_NEED);
  localparam fcnt_t TRACK_CNT = fcnt_t'(TRACK_AT);

  logic cs_rise, cs_fall, sc_rise, sc_fall;
  frame_t load_word;

  adcemu_edge #(.IDLE(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .lvl(cs_n), .rise(cs_rise), .fall(cs_fall));
  adcemu_edge #(.IDLE(1'b1)) u_sc_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sclk), .rise(sc_rise), .fall(sc_fall));

  adcemu_frame u_frame (
    .sample(sample), .short_mode(mode10), .word(load_word));

  logic   active_q, active_d;
  logic   oe_q, oe_d;
  logic   hold_q, hold_d;
  logic   mode_q, mode_d;
  logic   done_q, done_d;
  logic   abort_q, abort_d;
  fcnt_t  cnt_q, cnt_d;
  frame_t shr_q, shr_d;
  fcnt_t  need;

  assign need = mode_q ? SHORT_REQ : LONG_REQ;

  always_comb begin
    active_d = active_q;
    oe_d     = oe_q;
    hold_d   = hold_q;
    mode_d   = mode_q;
    cnt_d    = cnt_q;
    shr_d    = shr_q;
    done_d   = 1'b0;
    abort_d  = 1'b0;
    if (cs_fall) begin
      active_d = 1'b1;
      oe_d     = 1'b1;
      hold_d   = 1'b1;
      mode_d   = mode10;
      cnt_d    = '0;
      shr_d    = load_word;
    end else if (cs_rise) begin
      if (active_q) begin
        active_d = 1'b0;
        oe_d     = 1'b0;
        hold_d   = 1'b0;
        if (cnt_q >= need) done_d  = 1'b1;
        else               abort_d = 1'b1;
      end
    end else if (active_q) begin
      if (sc_fall) begin
        cnt_d = cnt_q + fcnt_t'(1);
        shr_d = {shr_q[FRAME_W-2:0], 1'b0};
        if (cnt_d == LAST_CNT) begin
          active_d = 1'b0;
          oe_d     = 1'b0;
          hold_d   = 1'b0;
          done_d   = 1'b1;
        end
      end
      if (sc_rise && (cnt_q >= TRACK_CNT)) hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      oe_q     <= 1'b0;
      hold_q   <= 1'b0;
      mode_q   <= 1'b0;
      done_q   <= 1'b0;
      abort_q  <= 1'b0;
      cnt_q    <= '0;
      shr_q    <= '0;
    end else begin
      active_q <= active_d;
      oe_q     <= oe_d;
      hold_q   <= hold_d;
      mode_q   <= mode_d;
      done_q   <= done_d;
      abort_q  <= abort_d;
      cnt_q    <= cnt_d;
      shr_q    <= shr_d;
    end
  end

  assign sdo    = oe_q & shr_q[FRAME_W-1];
  assign sdo_oe = oe_q;
  assign hold   = hold_q;
  assign done   = done_q;
  assign abort  = abort_q;
endmodule

// File: rtl/adcemu_port_chk.sv
module adcemu_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic sdo,
  input logic sdo_oe,
  input logic hold,
  input logic done,
  input logic abort
);
  p_start_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> (sdo_oe && hold && !sdo));

  p_oe_needs_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !$past(cs_n));

  p_cs_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> (!sdo_oe && !hold));

  p_oe_drop_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe) |-> (done ^ abort));

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && abort));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_abort_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);
endmodule

bind adcemu_port adcemu_port_chk u_chk (.*);

// File: tb/sim_adcemu_port.sv
module sim_adcemu_port;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, mode10;
  logic [11:0] sample;
  logic sdo, sdo_oe, hold, done, abort;
  int checks = 0;
  int fails = 0;
  int dcnt = 0;
  int acnt = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  adcemu_port u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sample(sample), .mode10(mode10), .sdo(sdo), .sdo_oe(sdo_oe),
    .hold(hold), .done(done), .abort(abort));

  // reference model, updated on each rising clock edge from the inputs
  bit q[$];
  int m_cnt, m_mode;
  bit m_act, m_oe, m_hold, m_done, m_abort, m_sdo, pcs, psc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_oe = 0; m_hold = 0; m_done = 0; m_abort = 0; m_sdo = 0;
      m_cnt = 0; m_mode = 0; pcs = 1; psc = 1; q.delete();
    end else begin
      m_done = 0; m_abort = 0;
      if (pcs && !cs_n) begin
        q.delete();
        for (int p = 0; p < 16; p++) begin
          if (p < 4) q.push_back(1'b0);
          else if (!mode10) q.push_back(sample[15 - p]);
          else if (p < 14) q.push_back(sample[13 - p]);
          else q.push_back(1'b0);
        end
        m_act = 1; m_oe = 1; m_hold = 1; m_cnt = 0; m_mode = mode10;
      end else if (!pcs && cs_n) begin
        if (m_act) begin
          m_act = 0; m_oe = 0; m_hold = 0;
          if (m_cnt >= (m_mode ? 14 : 16)) m_done = 1; else m_abort = 1;
        end
      end else if (m_act) begin
        if (psc && !sclk) begin
          m_cnt++;
          void'(q.pop_front());
          if (m_cnt == 16) begin m_act = 0; m_oe = 0; m_hold = 0; m_done = 1; end
        end
        if (!psc && sclk && m_cnt >= 13) m_hold = 0;
      end
      m_sdo = (m_oe && q.size() > 0) ? q[0] : 1'b0;
      pcs = cs_n; psc = sclk;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 sdo", {15'b0, sdo}, {15'b0, m_sdo});
      chk("R1 sdo_oe", {15'b0, sdo_oe}, {15'b0, m_oe});
      chk("R5 hold", {15'b0, hold}, {15'b0, m_hold});
      chk("R6 done", {15'b0, done}, {15'b0, m_done});
      chk("R7 abort", {15'b0, abort}, {15'b0, m_abort});
      if (!sdo_oe) chk("R11 idle sdo", {15'b0, sdo}, 16'h0);
      if (done) dcnt++;
      if (abort) acnt++;
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame: nfall falling serial edges, sample scrambled after the latch
  task automatic frame(input logic [11:0] s, input logic m, input int nfall,
                       output logic [15:0] w);
    w = '0;
    sample = s; mode10 = m;
    @(negedge clk); cs_n = 1'b0;
    wait_n(2);
    dcnt = 0; acnt = 0;
    sample = ~s;
    w = {w[14:0], sdo};
    for (int k = 1; k <= nfall; k++) begin
      sclk = 1'b0; wait_n(2);
      if (k <= 15) w = {w[14:0], sdo};
      sclk = 1'b1; wait_n(2);
    end
    cs_n = 1'b1; wait_n(3);
  endtask

  initial begin
    logic [15:0] w;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; mode10 = 1'b0; sample = '0;
    wait_n(3);
    chk("R11 reset", {11'b0, sdo, sdo_oe, hold, done, abort}, 16'h0);
    rst_n = 1'b1;
    wait_n(2);
    chk("R11 after reset", {11'b0, sdo, sdo_oe, hold, done, abort}, 16'h0);

    frame(12'hA5C, 1'b0, 16, w);
    chk("R3 12-bit word", w, 16'h0A5C);
    chk("R6 done count", 16'(dcnt), 16'd1);
    chk("R10 abort count", 16'(acnt), 16'd0);

    frame(12'hFFF, 1'b0, 16, w);
    chk("R3 all ones", w, 16'h0FFF);

    frame(12'h2B7, 1'b1, 16, w);
    chk("R4 10-bit word", w, {4'b0, 10'h2B7, 2'b0});
    chk("R10 done once", 16'(dcnt), 16'd1);

    frame(12'h3FF, 1'b1, 16, w);
    chk("R4 10-bit ones", w, 16'h0FFC);

    frame(12'h123, 1'b0, 8, w);
    chk("R7 abort count", 16'(acnt), 16'd1);
    chk("R7 no done", 16'(dcnt), 16'd0);
    chk("R7 oe off", {15'b0, sdo_oe}, 16'h0);

    frame(12'h155, 1'b1, 14, w);
    chk("R8 done at 14", 16'(dcnt), 16'd1);
    chk("R8 no abort", 16'(acnt), 16'd0);
    frame(12'h155, 1'b1, 15, w);
    chk("R8 done at 15", 16'(dcnt), 16'd1);
    frame(12'h155, 1'b1, 13, w);
    chk("R8 abort at 13", 16'(acnt), 16'd1);
    frame(12'h155, 1'b0, 15, w);
    chk("R7 12-bit at 15", 16'(acnt), 16'd1);

    // serial clock with chip select high
    for (int k = 0; k < 6; k++) begin
      sclk = 1'b0; wait_n(2);
      chk("R9 ignored", {12'b0, sdo, sdo_oe, hold, done}, 16'h0);
      sclk = 1'b1; wait_n(2);
    end
    frame(12'h9C3, 1'b0, 16, w);
    chk("R9 restart", w, 16'h09C3);

    // hold timing
    sample = 12'h777; mode10 = 1'b0;
    @(negedge clk); cs_n = 1'b0; wait_n(2);
    for (int k = 1; k <= 13; k++) begin
      sclk = 1'b0; wait_n(2);
      if (k == 13) chk("R5 hold after 13th fall", {15'b0, hold}, 16'h1);
      sclk = 1'b1; wait_n(2);
    end
    chk("R5 track after rise", {15'b0, hold}, 16'h0);
    chk("R5 oe still on", {15'b0, sdo_oe}, 16'h1);
    for (int k = 14; k <= 18; k++) begin
      sclk = 1'b0; wait_n(2); sclk = 1'b1; wait_n(2);
    end
    chk("R9 edges after end", {15'b0, sdo_oe}, 16'h0);
    cs_n = 1'b1; wait_n(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule